// File: doc/BRIEF.md
# PMIC Register Bridge Controller

The bridge lets a host processor reach the registers of an external power-management chip. On the host side it is a plain memory-mapped register bus with single-cycle, combinational read data. On the slave side it drives a request/response port that stands in for the serial link.

A read is launched by writing a slave register offset into the read-launch register. No separate start bit exists. The host then polls the read-back register. That register carries a busy flag, the 16-bit returned value and an echo of the address that was read, so software can confirm that the reply belongs to its own request.

A host write that lands inside the slave window becomes a slave write. The window is a range of host addresses at a fixed base. The offset and the data enter an ordered write queue, and the queue's full and empty state is visible in a status register. The addressing mode is a parameter, and it sets both the window base and size and the rule used to form the echoed address.

Top module: `pmic_bridge`

## Requirements
- R1: A host write to the read-launch register (host address 0x10) starts a read of the slave offset `wdata & (window size - 1)`. The slave port then shows a read request (`slv_req_wr` = 0) carrying that offset, and no other host action issues a read.
- R2: Bit 31 of the read-back register (host address 0x14) reads 1 from the cycle after a read launch until the read response has been captured, and reads 0 after that.
- R3: In the read-back register, bits 15:0 hold the returned slave data and bits 30:16 hold the echoed address. With the 10-bit addressing mode the echo is bits 14:0 of the read offset. With the 12-bit and 15-bit modes the echo is bits 16:2 of the offset.
- R4: The slave window starts at host address 0x8000 and spans 4 KiB in the 10-bit mode and 16 KiB in the 12-bit mode. In the 15-bit mode it starts at 0x20000 and spans 128 KiB. A host write inside the window queues {address minus base, wdata[15:0]}. A host write outside the window queues nothing.
- R5: The status register (host address 0x18) shows bit 10 = 1 exactly when the write queue holds no entry. It shows bit 11 = 1 exactly when the queue holds FIFO_DEPTH entries (8 by default).
- R6: A window write while the queue is full is discarded. It sets status bit 12, which stays 1 until reset.
- R7: A read launch written while bit 31 of the read-back register is 1 has no effect. The slave sees no second read, and the echo and data keep the values of the first read.
- R8: Queued writes reach the slave port in arrival order. A launched read waits until every write queued before it has been accepted. While a read awaits its response, no request is presented.
- R9: A request that is presented but not yet accepted (`slv_req_rdy` = 0) keeps its kind, address and data unchanged until it is accepted.
- R10: After reset the status register reads 0x400, the read-back register reads 0, and no slave request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_sel | input | 1 | Host access strobe |
| hst_wr | input | 1 | Host access is a write |
| hst_addr | input | HADDR_W | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid in the access cycle |
| slv_req_vld | output | 1 | Slave request presented |
| slv_req_wr | output | 1 | 1 = write request, 0 = read request |
| slv_req_addr | output | 17 | Slave register offset |
| slv_req_data | output | 16 | Slave write data |
| slv_req_rdy | input | 1 | Slave accepts the presented request |
| slv_rsp_vld | input | 1 | Read response strobe |
| slv_rsp_data | input | 16 | Read response value |

## Verification
The checker watches several rules on every cycle. A read launch must raise busy, and a captured response must drop it. The overflow flag must be set by a write to a full queue, and it must then stay set. A stalled request must hold steady, a write into a non-full queue must grow the count by one, and the slave port must stay quiet while a read is outstanding. The remaining behaviour needs the bench's scenarios: the exact queue flags at every fill level, the discarding of the ninth write, and the order of writes and reads at the slave. They also cover the echo and data contents in both address modes and the rejection of a second launch. None of these can be judged from a single cycle.

// File: rtl/pmic_br_pkg.sv
// Package: shared types and derived constants for the PMIC bridge.
// Assumes host addresses are byte addresses, and that the three addressing
// modes differ only in window placement and in the read-echo rule.
package pmic_br_pkg;

    localparam int OFF_W  = 17;   // slave offset width
    localparam int DATA_W = 16;   // slave data width
    localparam int ECHO_W = 15;   // echoed address width

    // Host-visible register offsets
    localparam int REG_RD_LAUNCH = 'h10;
    localparam int REG_RD_BACK   = 'h14;
    localparam int REG_Q_STATUS  = 'h18;

    typedef enum logic [1:0] {
        AMODE_10 = 2'd0,
        AMODE_12 = 2'd1,
        AMODE_15 = 2'd2
    } amode_e;

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] data;
    } wr_ent_t;

    function automatic int win_base(amode_e m);
        return (m == AMODE_15) ? 'h20000 : 'h8000;
    endfunction

    function automatic int win_size(amode_e m);
        case (m)
            AMODE_10: return 'h1000;
            AMODE_12: return 'h4000;
            default:  return 'h20000;
        endcase
    endfunction

endpackage

// File: rtl/pmic_br_fifo.sv
// Module: ordered write queue holding {offset, data} entries.
// Assumes the caller never pushes when full nor pops when empty;
// DEPTH need not be a power of two.
module pmic_br_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;

    // Storage write port
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Head and flags
    always_comb begin
        dout  = mem[rp];
        full  = (cnt == CW'(DEPTH));
        empty = (cnt == '0);
    end

endmodule

// File: rtl/pmic_br_hostif.sv
// Module: host register decode. Splits host writes into read launches and
// window writes, and assembles the read data of the three registers.
// Assumes single-cycle host accesses; unmapped reads return zero.
module pmic_br_hostif
    import pmic_br_pkg::*;
#(
    parameter amode_e MODE    = AMODE_12,
    parameter int     HADDR_W = 18,
    localparam int    WBASE   = win_base(MODE),
    localparam int    WSIZE   = win_size(MODE)
) (
    input  logic               hst_sel,
    input  logic               hst_wr,
    input  logic [HADDR_W-1:0] hst_addr,
    input  logic [31:0]        hst_wdata,
    output logic [31:0]        hst_rdata,
    output logic               cmd_wr,
    output logic [OFF_W-1:0]   cmd_off,
    output logic               win_wr,
    output wr_ent_t            win_ent,
    input  logic               busy,
    input  logic [ECHO_W-1:0]  rb_echo,
    input  logic [DATA_W-1:0]  rb_data,
    input  logic               q_full,
    input  logic               q_empty,
    input  logic               q_ovf
);

    logic [31:0] a32;
    logic        in_win;

    // Window hit test and offset formation
    always_comb begin
        a32     = 32'(hst_addr);
        in_win  = (a32 >= 32'(WBASE)) && (a32 < 32'(WBASE + WSIZE));
        win_wr  = hst_sel && hst_wr && in_win;
        win_ent.off  = OFF_W'(a32 - 32'(WBASE));
        win_ent.data = hst_wdata[DATA_W-1:0];
        cmd_wr  = hst_sel && hst_wr && (a32 == 32'(REG_RD_LAUNCH));
        cmd_off = hst_wdata[OFF_W-1:0] & OFF_W'(WSIZE - 1);
    end

    // Read data multiplexer
    always_comb begin
        hst_rdata = '0;
        if (hst_sel && !hst_wr) begin
            if (a32 == 32'(REG_RD_BACK))
                hst_rdata = {busy, rb_echo, rb_data};
            else if (a32 == 32'(REG_Q_STATUS))
                hst_rdata = {19'b0, q_ovf, q_full, q_empty, 10'b0};
        end
    end

endmodule

// File: rtl/pmic_br_seq.sv
// Module: slave-port sequencer. Drains the write queue in order, holds a
// launched read until all writes queued ahead of it are accepted, then waits
// for the response and captures data and echo. One read at a time.
// Assumes the slave answers a read only after accepting it.
module pmic_br_seq
    import pmic_br_pkg::*;
#(
    parameter amode_e MODE  = AMODE_12,
    parameter int     DEPTH = 8,
    localparam int    CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [OFF_W-1:0]  cmd_off,
    input  logic [CW-1:0]     q_cnt,
    input  logic              q_empty,
    input  wr_ent_t           q_head,
    output logic              q_pop,
    output logic              slv_req_vld,
    output logic              slv_req_wr,
    output logic [OFF_W-1:0]  slv_req_addr,
    output logic [DATA_W-1:0] slv_req_data,
    input  logic              slv_req_rdy,
    input  logic              slv_rsp_vld,
    input  logic [DATA_W-1:0] slv_rsp_data,
    output logic              busy,
    output logic              rd_wait,
    output logic [ECHO_W-1:0] rb_echo,
    output logic [DATA_W-1:0] rb_data
);

    logic              rd_pend;
    logic [CW-1:0]     rd_ahead;
    logic [OFF_W-1:0]  rd_off;
    logic              rd_go;
    logic [ECHO_W-1:0] echo_nxt;

    // Echo rule chosen by addressing mode
    generate
        if (MODE == AMODE_10) begin : g_echo_low
            assign echo_nxt = rd_off[ECHO_W-1:0];
        end else begin : g_echo_word
            assign echo_nxt = rd_off[ECHO_W+1:2];
        end
    endgenerate

    // Request selection: a due read wins, else the queue head
    always_comb begin
        rd_go        = rd_pend && (rd_ahead == '0);
        slv_req_vld  = rd_go || (!q_empty && !rd_wait);
        slv_req_wr   = !rd_go;
        slv_req_addr = rd_go ? rd_off : q_head.off;
        slv_req_data = rd_go ? '0 : q_head.data;
        q_pop        = slv_req_vld && slv_req_wr && slv_req_rdy;
        busy         = rd_pend || rd_wait;
    end

    // Read tracking: launch, ahead-count, issue, response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend  <= 1'b0;
            rd_wait  <= 1'b0;
            rd_ahead <= '0;
            rd_off   <= '0;
            rb_echo  <= '0;
            rb_data  <= '0;
        end else begin
            if (cmd_wr && !busy) begin
                rd_pend  <= 1'b1;
                rd_off   <= cmd_off;
                rd_ahead <= q_cnt - CW'(q_pop);
            end else if (rd_pend && q_pop) begin
                rd_ahead <= rd_ahead - 1'b1;
            end
            if (rd_go && slv_req_rdy) begin
                rd_pend <= 1'b0;
                rd_wait <= 1'b1;
            end
            if (rd_wait && slv_rsp_vld) begin
                rd_wait <= 1'b0;
                rb_data <= slv_rsp_data;
                rb_echo <= echo_nxt;
            end
        end
    end

endmodule

// File: rtl/pmic_bridge.sv
// Module: top of the PMIC register bridge. Connects host decode, write queue
// and slave sequencer, and keeps the sticky overflow flag.
// Assumes one host access per cycle and a slave model behind slv_*.
module pmic_bridge
    import pmic_br_pkg::*;
#(
    parameter amode_e MODE       = AMODE_12,
    parameter int     FIFO_DEPTH = 8,
    parameter int     HADDR_W    = 18,
    localparam int    CW         = $clog2(FIFO_DEPTH + 1),
    localparam int    EW         = OFF_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_sel,
    input  logic               hst_wr,
    input  logic [HADDR_W-1:0] hst_addr,
    input  logic [31:0]        hst_wdata,
    output logic [31:0]        hst_rdata,
    output logic               slv_req_vld,
    output logic               slv_req_wr,
    output logic [OFF_W-1:0]   slv_req_addr,
    output logic [DATA_W-1:0]  slv_req_data,
    input  logic               slv_req_rdy,
    input  logic               slv_rsp_vld,
    input  logic [DATA_W-1:0]  slv_rsp_data
);

    logic              cmd_wr, win_wr, q_push, q_pop;
    logic [OFF_W-1:0]  cmd_off;
    wr_ent_t           win_ent, q_head;
    logic [EW-1:0]     q_dout;
    logic [CW-1:0]     q_cnt;
    logic              q_full, q_empty, q_ovf;
    logic              rd_busy, rd_wait;
    logic [ECHO_W-1:0] rb_echo;
    logic [DATA_W-1:0] rb_data;

    assign q_push = win_wr && !q_full;
    assign q_head = wr_ent_t'(q_dout);

    // Sticky overflow on a discarded window write
    always_ff @(posedge clk) begin
        if (!rst_n)                q_ovf <= 1'b0;
        else if (win_wr && q_full) q_ovf <= 1'b1;
    end

    pmic_br_hostif #(.MODE(MODE), .HADDR_W(HADDR_W)) u_host (
        .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .cmd_wr(cmd_wr), .cmd_off(cmd_off),
        .win_wr(win_wr), .win_ent(win_ent),
        .busy(rd_busy), .rb_echo(rb_echo), .rb_data(rb_data),
        .q_full(q_full), .q_empty(q_empty), .q_ovf(q_ovf)
    );

    pmic_br_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .din(win_ent), .pop(q_pop), .dout(q_dout),
        .cnt(q_cnt), .full(q_full), .empty(q_empty)
    );

    pmic_br_seq #(.MODE(MODE), .DEPTH(FIFO_DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_off(cmd_off),
        .q_cnt(q_cnt), .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
        .slv_req_vld(slv_req_vld), .slv_req_wr(slv_req_wr),
        .slv_req_addr(slv_req_addr), .slv_req_data(slv_req_data),
        .slv_req_rdy(slv_req_rdy),
        .slv_rsp_vld(slv_rsp_vld), .slv_rsp_data(slv_rsp_data),
        .busy(rd_busy), .rd_wait(rd_wait),
        .rb_echo(rb_echo), .rb_data(rb_data)
    );

endmodule

// File: rtl/pmic_bridge_chk.sv
// Module: cycle-level rule checker for pmic_bridge, attached by bind.
// Assumes the internal names of the top module listed in the bind below.
module pmic_bridge_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_wr,
    input logic          rd_busy,
    input logic          rd_wait,
    input logic          win_wr,
    input logic          q_full,
    input logic          q_pop,
    input logic [CW-1:0] q_cnt,
    input logic          q_ovf,
    input logic          slv_req_vld,
    input logic          slv_req_wr,
    input logic          slv_req_rdy,
    input logic [16:0]   slv_req_addr,
    input logic [15:0]   slv_req_data,
    input logic          slv_rsp_vld
);

    AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> rd_busy); // R2
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_wait && slv_rsp_vld) |=> !rd_busy); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && q_full) |=> q_ovf); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q_ovf |=> q_ovf); // R6
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && !q_full && !q_pop) |=> (q_cnt == $past(q_cnt) + 1'b1)); // R4
    AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wait |-> !slv_req_vld); // R8
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_req_vld && !slv_req_rdy) |=> (slv_req_vld && $stable(slv_req_wr)
        && $stable(slv_req_addr) && $stable(slv_req_data))); // R9

endmodule

bind pmic_bridge pmic_bridge_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .rd_busy(rd_busy),
    .rd_wait(rd_wait), .win_wr(win_wr), .q_full(q_full), .q_pop(q_pop),
    .q_cnt(q_cnt), .q_ovf(q_ovf), .slv_req_vld(slv_req_vld),
    .slv_req_wr(slv_req_wr), .slv_req_rdy(slv_req_rdy),
    .slv_req_addr(slv_req_addr), .slv_req_data(slv_req_data),
    .slv_rsp_vld(slv_rsp_vld)
);

// File: tb/pmic_bridge_test.sv
// Slave model: logs accepted requests and answers reads after a fixed delay
// with data = offset[15:0] ^ 16'hA5C3.
module pmic_slave_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rdy_en,
    input  logic        req_vld,
    input  logic        req_wr,
    input  logic [16:0] req_addr,
    input  logic [15:0] req_data,
    output logic        req_rdy,
    output logic        rsp_vld,
    output logic [15:0] rsp_data
);
    logic [33:0] lg [32];
    int          lg_n;
    int          cnt;
    logic [16:0] raddr;

    assign req_rdy = rdy_en;

    // Accept, log and answer requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lg_n <= 0; cnt <= 0; rsp_vld <= 1'b0; rsp_data <= '0; raddr <= '0;
        end else begin
            if (cnt != 0) cnt <= cnt - 1;
            rsp_vld  <= (cnt == 1);
            rsp_data <= raddr[15:0] ^ 16'hA5C3;
            if (req_vld && req_rdy) begin
                if (lg_n < 32) lg[lg_n] <= {req_wr, req_addr, req_data};
                lg_n <= lg_n + 1;
                if (!req_wr) begin
                    cnt   <= 3;
                    raddr <= req_addr;
                end
            end
        end
    end
endmodule

// Bench: 12-bit-mode instance uut plus 10-bit-mode instance uut_n on a
// shared host bus; sweeps queue fill levels and read offsets.
module pmic_bridge_test;
    import pmic_br_pkg::*;

    logic        clk = 0, rst_n = 0;
    logic        hst_sel = 0, hst_wr = 0;
    logic [17:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] rd_a, rd_b;
    logic        rdy_en = 0;
    int          n_chk = 0, n_fail = 0, cyc = 0;

    logic        a_vld, a_wr, a_rdy, a_rv, b_vld, b_wr, b_rdy, b_rv;
    logic [16:0] a_addr, b_addr;
    logic [15:0] a_data, b_data, a_rd, b_rd;

    always #10 clk = ~clk;

    pmic_bridge #(.MODE(AMODE_12)) uut (
        .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(rd_a),
        .slv_req_vld(a_vld), .slv_req_wr(a_wr), .slv_req_addr(a_addr),
        .slv_req_data(a_data), .slv_req_rdy(a_rdy),
        .slv_rsp_vld(a_rv), .slv_rsp_data(a_rd));
    pmic_slave_model sm_a (.clk(clk), .rst_n(rst_n), .rdy_en(rdy_en),
        .req_vld(a_vld), .req_wr(a_wr), .req_addr(a_addr), .req_data(a_data),
        .req_rdy(a_rdy), .rsp_vld(a_rv), .rsp_data(a_rd));

    pmic_bridge #(.MODE(AMODE_10)) uut_n (
        .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(rd_b),
        .slv_req_vld(b_vld), .slv_req_wr(b_wr), .slv_req_addr(b_addr),
        .slv_req_data(b_data), .slv_req_rdy(b_rdy),
        .slv_rsp_vld(b_rv), .slv_rsp_data(b_rd));
    pmic_slave_model sm_b (.clk(clk), .rst_n(rst_n), .rdy_en(rdy_en),
        .req_vld(b_vld), .req_wr(b_wr), .req_addr(b_addr), .req_data(b_data),
        .req_rdy(b_rdy), .rsp_vld(b_rv), .rsp_data(b_rd));

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
            finish_run();
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(int a, logic [31:0] d);
        @(negedge clk);
        hst_sel = 1; hst_wr = 1; hst_addr = 18'(a); hst_wdata = d;
        @(negedge clk);
        hst_sel = 0; hst_wr = 0;
    endtask

    task automatic bus_rd(int a, output logic [31:0] va, output logic [31:0] vb);
        hst_sel = 1; hst_wr = 0; hst_addr = 18'(a);
        #1; va = rd_a; vb = rd_b;
        hst_sel = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wait_idle();
        logic [31:0] va, vb;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            bus_rd(REG_RD_BACK, va, vb);
            if (!va[31] && !vb[31]) break;
        end
    endtask

    function automatic logic [31:0] exp_rb(bit narrow, logic [16:0] off);
        logic [14:0] e;
        e = narrow ? off[14:0] : off[16:2];
        return {1'b0, e, off[15:0] ^ 16'hA5C3};
    endfunction

    logic [31:0] va, vb;

    initial begin
        do_reset();

        // R10: reset state
        @(negedge clk);
        bus_rd(REG_Q_STATUS, va, vb); check("R10 status", va, 32'h400);
        bus_rd(REG_RD_BACK, va, vb);  check("R10 readback", va, 32'h0);
        check("R10 no request", {31'b0, a_vld}, 32'h0);

        // R5/R6: fill sweep with slave stalled
        rdy_en = 0;
        for (int k = 1; k <= 9; k++) begin
            bus_wr('h8000 + 4 * k, 32'(16'h1000 + k));
            bus_rd(REG_Q_STATUS, va, vb);
            check("R5 empty flag", {31'b0, va[10]}, 32'h0);
            check("R5 full flag", {31'b0, va[11]}, (k >= 8) ? 32'h1 : 32'h0);
            check("R6 overflow flag", {31'b0, va[12]}, (k >= 9) ? 32'h1 : 32'h0);
        end
        check("R9 stalled head held", {15'b0, a_addr}, 32'h4);
        rdy_en = 1;
        repeat (12) @(negedge clk);
        bus_rd(REG_Q_STATUS, va, vb);
        check("R5 drained empty", va, 32'h1400);   // R6 sticky stays set
        check("R6 ninth write dropped", 32'(sm_a.lg_n), 32'd8);
        for (int k = 1; k <= 8; k++)
            check("R8 write order", 32'(sm_a.lg[k-1]),
                  32'({1'b1, 17'(4 * k), 16'(16'h1000 + k)}));

        // R4: window edges
        do_reset();
        bus_wr('h8000 - 4, 32'h1111);
        bus_wr('h8000 + 'h4000, 32'h2222);
        bus_wr(REG_Q_STATUS, 32'hFFFF);
        repeat (3) @(negedge clk);
        check("R4 outside window ignored", 32'(sm_a.lg_n), 32'd0);
        bus_rd(REG_Q_STATUS, va, vb); check("R4 queue still empty", va, 32'h400);
        rdy_en = 1;
        bus_wr('h8000 + 'h3FFC, 32'hABCD5A5A);
        repeat (3) @(negedge clk);
        check("R4 last window word", 32'(sm_a.lg[0]), 32'({1'b1, 17'h3FFC, 16'h5A5A}));

        // R1/R2/R3: read sweep in both modes
        for (int i = 0; i < 16; i++) begin
            logic [31:0] off;
            off = 32'((i * 32'h0A74 + 32'h1) & 32'h1FFFC) | 32'(i & 3);
            bus_wr(REG_RD_LAUNCH, off);
            bus_rd(REG_RD_BACK, va, vb);
            check("R2 busy after launch", {31'b0, va[31]}, 32'h1);
            wait_idle();
            @(negedge clk);
            bus_rd(REG_RD_BACK, va, vb);
            check("R3 wide readback", va, exp_rb(0, 17'(off & 32'h3FFF)));
            check("R3 narrow readback", vb, exp_rb(1, 17'(off & 32'hFFF)));
        end
        check("R1 read request offset", 32'(sm_a.lg[sm_a.lg_n-1]),
              32'({1'b0, 17'(((15 * 32'h0A74 + 1) & 32'h1FFFC | 3) & 32'h3FFF), 16'h0}));

        // R7: second launch while busy
        do_reset();
        rdy_en = 0;
        bus_wr(REG_RD_LAUNCH, 32'h0124);
        bus_wr(REG_RD_LAUNCH, 32'h0F00);
        rdy_en = 1;
        wait_idle();
        @(negedge clk);
        bus_rd(REG_RD_BACK, va, vb);
        check("R7 first read kept", va, exp_rb(0, 17'h0124));
        check("R7 single read issued", 32'(sm_a.lg_n), 32'd1);

        // R8: read ordered behind earlier writes, ahead of later ones
        do_reset();
        rdy_en = 0;
        for (int k = 0; k < 3; k++) bus_wr('h8000 + 8 * k, 32'(k + 1));
        bus_wr(REG_RD_LAUNCH, 32'h0040);
        for (int k = 3; k < 5; k++) bus_wr('h8000 + 8 * k, 32'(k + 1));
        check("R8 nothing while stalled", 32'(sm_a.lg_n), 32'd0);
        rdy_en = 1;
        wait_idle();
        repeat (6) @(negedge clk);
        check("R8 total requests", 32'(sm_a.lg_n), 32'd6);
        for (int k = 0; k < 6; k++) begin
            logic [33:0] e;
            if (k < 3)       e = {1'b1, 17'(8 * k), 16'(k + 1)};
            else if (k == 3) e = {1'b0, 17'h40, 16'h0};
            else             e = {1'b1, 17'(8 * (k - 1)), 16'(k)};
            check("R8 mixed order", 32'(sm_a.lg[k]), 32'(e));
            check("R8 mixed order hi", {31'b0, sm_a.lg[k][33]}, {31'b0, e[33]});
        end
        finish_run();
    end
endmodule